// File: doc/BRIEF.md
# Byte Logger Store/Erase Sequencer for a Serial EEPROM

This block sits above a serial EEPROM bus master and turns two simple requests into single-byte write commands. A store request writes one byte at the next free location of a 128-byte memory. The block then advances its write pointer and its count of stored bytes. An erase request sweeps every location from the lowest address upward, writing zero to each one. It then resets the pointer and the count.

Each write goes to the master as a one-cycle start pulse, with the address and the data held steady alongside it. The master answers with a one-cycle done pulse once the transfer has finished and been closed with a stop. Any wait for the memory's internal write cycle is the master's concern, handled there by acknowledge polling. The sequencer raises busy from the cycle after it accepts a request until the done of the last write it issued. Requests that arrive while it is busy are dropped.

Top module: `eeprom_store_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), busy, wr_start, cur_addr and byte_count are all 0.
- R2: A store request accepted while idle raises busy and a one-cycle wr_start in the cycle after the request edge. During that cycle cur_addr shows the current pointer and wr_data shows the requested byte.
- R3: At the clock edge where wr_done is seen for a store, cur_addr and byte_count each increase by one and busy falls.
- R4: When the pointer advances from address 127, the next address is 0.
- R5: byte_count is 8 bits wide and rolls over from 255 to 0 on a store.
- R6: An erase request accepted while idle sets cur_addr to 0 and issues 128 writes of the value 0 to addresses 0, 1, ..., 127 in that order. Each write after the first starts with wr_start in the cycle after the previous write's done edge.
- R7: At the done edge of the 128th erase write, busy falls, cur_addr is 0 and byte_count is 0.
- R8: While busy, store and erase requests are ignored. They start no write, and they change neither wr_data nor the progress of the operation in flight.
- R9: If store and erase are requested on the same idle edge, the erase is taken and the store is dropped.
- R10: A wr_done pulse while idle changes neither cur_addr nor byte_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| store_req | input | 1 | Store strobe, one cycle |
| store_data | input | 8 | Byte to store, sampled with store_req |
| erase_req | input | 1 | Erase-all strobe, one cycle |
| wr_done | input | 1 | Master finished the current write, one cycle |
| busy | output | 1 | An operation is in progress |
| wr_start | output | 1 | Command pulse to the master for one byte write |
| wr_data | output | 8 | Byte for the write in flight |
| cur_addr | output | 7 | Write pointer; also the address of the write in flight |
| byte_count | output | 8 | Number of bytes stored since the last erase |

## Verification
Every result is due one edge after its cause. wr_start, busy and wr_data follow the request edge. The pointer, the count and the fall of busy follow the edge where wr_done is seen. The next erase command follows that same done edge. The bench drives inputs on the falling edge and samples 1 ns after the rising edge it expects the change on, so each check lands in the first cycle the new value is valid. Between a command and its done, the bench waits a random 0 to 3 cycles and sometimes throws in stray requests. On each of those waiting cycles it checks that wr_start stays low and busy stays high.

// File: rtl/eess_pkg.sv
// Shared types for the store/erase sequencer.
// Assumes: nothing beyond a single clock domain.
package eess_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STORE = 2'd1,
        ST_ERASE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/eess_pointer.sv
// Write pointer and stored-byte counter.
// The pointer steps by one and wraps at MEM_SIZE. A clear wins over a step.
// The counter wraps at its natural width.
// Assumes: step and clear come from the controller and are never both set.
module eess_pointer #(
    parameter int MEM_SIZE = 128,
    parameter int CNT_W    = 8,
    localparam int AW      = $clog2(MEM_SIZE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             clear,
    input  logic             cnt_inc,
    input  logic             cnt_clr,
    output logic [AW-1:0]    addr,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);
    localparam logic [AW-1:0] LAST = AW'(MEM_SIZE - 1);

    // Flag the highest location so the controller and the wrap share one compare
    always_comb at_last = (addr == LAST);

    // Pointer register: clear, wrap at the top, or step
    always_ff @(posedge clk) begin
        if (!rst_n)       addr <= '0;
        else if (clear)   addr <= '0;
        else if (step)    addr <= at_last ? '0 : addr + 1'b1;
    end

    // Stored-byte counter with natural rollover
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (cnt_clr) cnt <= '0;
        else if (cnt_inc) cnt <= cnt + 1'b1;
    end

    assert_wrap_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && addr == LAST) |=> (addr == '0));

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_inc && !cnt_clr) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/eess_ctrl.sv
// Operation controller. It accepts one request while idle, issues write
// commands to the bus master and steers the pointer and counter.
// Erase wins over store on the same edge.
// Assumes: wr_done is a one-cycle pulse per issued command.
module eess_ctrl
    import eess_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic store_req,
    input  logic erase_req,
    input  logic wr_done,
    input  logic at_last,
    output logic busy,
    output logic wr_start,
    output logic load_data,
    output logic clear,
    output logic step,
    output logic cnt_inc,
    output logic cnt_clr
);
    seq_state_t state;
    logic       idle, store_fin, erase_step, erase_fin;

    // Decode the acceptance and completion events of the current state
    always_comb begin
        idle       = (state == ST_IDLE);
        clear      = idle && erase_req;
        load_data  = idle && store_req && !erase_req;
        store_fin  = (state == ST_STORE) && wr_done;
        erase_step = (state == ST_ERASE) && wr_done;
        erase_fin  = erase_step && at_last;
        step       = store_fin || erase_step;
        cnt_inc    = store_fin;
        cnt_clr    = erase_fin;
        busy       = !idle;
    end

    // State register: enter an operation on request, leave it on its last done
    always_ff @(posedge clk) begin
        if (!rst_n)                  state <= ST_IDLE;
        else if (clear)              state <= ST_ERASE;
        else if (load_data)          state <= ST_STORE;
        else if (store_fin || erase_fin) state <= ST_IDLE;
    end

    // Command pulse: one per accepted request and one per further erase location
    always_ff @(posedge clk) begin
        if (!rst_n) wr_start <= 1'b0;
        else        wr_start <= clear || load_data || (erase_step && !at_last);
    end

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> busy);

    assert_erase_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_fin |=> !busy);
endmodule

// File: rtl/eeprom_store_seq.sv
// Top of the store/erase sequencer. It ties the controller to the pointer
// and holds the byte for the write in flight (zero during an erase).
// Assumes: the master samples cur_addr and wr_data with wr_start and keeps
// using them until it pulses wr_done.
module eeprom_store_seq #(
    parameter int MEM_SIZE   = 128,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 8,
    parameter logic [DATA_W-1:0] ERASE_FILL = '0,
    localparam int AW        = $clog2(MEM_SIZE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_req,
    input  logic [DATA_W-1:0] store_data,
    input  logic              erase_req,
    input  logic              wr_done,
    output logic              busy,
    output logic              wr_start,
    output logic [DATA_W-1:0] wr_data,
    output logic [AW-1:0]     cur_addr,
    output logic [CNT_W-1:0]  byte_count
);
    logic load_data, clear, step, cnt_inc, cnt_clr, at_last;

    eess_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .store_req (store_req),
        .erase_req (erase_req),
        .wr_done   (wr_done),
        .at_last   (at_last),
        .busy      (busy),
        .wr_start  (wr_start),
        .load_data (load_data),
        .clear     (clear),
        .step      (step),
        .cnt_inc   (cnt_inc),
        .cnt_clr   (cnt_clr)
    );

    eess_pointer #(.MEM_SIZE(MEM_SIZE), .CNT_W(CNT_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .clear   (clear),
        .cnt_inc (cnt_inc),
        .cnt_clr (cnt_clr),
        .addr    (cur_addr),
        .cnt     (byte_count),
        .at_last (at_last)
    );

    // Write data register: fill value for an erase, request byte for a store
    always_ff @(posedge clk) begin
        if (!rst_n)         wr_data <= '0;
        else if (clear)     wr_data <= ERASE_FILL;
        else if (load_data) wr_data <= store_data;
    end

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_done) |=> ($stable(cur_addr) && $stable(byte_count) && $stable(wr_data)));

    assert_idle_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !store_req && !erase_req) |=> ($stable(cur_addr) && $stable(byte_count)));

    assert_erase_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && erase_req) |=> (cur_addr == '0 && wr_start && wr_data == ERASE_FILL));
endmodule

// File: tb/sim_eeprom_store_seq.sv
module sim_eeprom_store_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       store_req = 1'b0, erase_req = 1'b0, wr_done = 1'b0;
    logic [7:0] store_data = '0;
    logic       busy, wr_start;
    logic [7:0] wr_data;
    logic [6:0] cur_addr;
    logic [7:0] byte_count;

    int checks = 0, errors = 0;
    int exp_addr = 0, exp_cnt = 0;
    int cycles = 0;

    always #4 clk = ~clk;   // 125 MHz

    eeprom_store_seq u0 (
        .clk(clk), .rst_n(rst_n), .store_req(store_req), .store_data(store_data),
        .erase_req(erase_req), .wr_done(wr_done), .busy(busy), .wr_start(wr_start),
        .wr_data(wr_data), .cur_addr(cur_addr), .byte_count(byte_count)
    );

    function automatic int next_addr(input int a);
        return (a + 1) % 128;
    endfunction

    function automatic int next_cnt(input int c);
        return (c + 1) % 256;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Act as the bus master: wait dly cycles, maybe with stray requests, then pulse done
    task automatic serve(input int dly, input bit noise);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            wr_done    = 1'b0;
            store_req  = noise;
            erase_req  = noise && ($urandom % 2 == 1);
            store_data = 8'($urandom);
            @(posedge clk); #1;
            chk("R8", wr_start, 0, "no command while waiting");
            chk("R8", busy, 1, "busy while waiting");
        end
        @(negedge clk);
        store_req = 1'b0; erase_req = 1'b0; wr_done = 1'b1;
        @(posedge clk); #1;
    endtask

    task automatic do_store(input logic [7:0] d, input bit noise);
        @(negedge clk);
        wr_done = 1'b0; store_req = 1'b1; erase_req = 1'b0; store_data = d;
        @(posedge clk); #1;
        chk("R2", busy, 1, "busy after store request");
        chk("R2", wr_start, 1, "store command pulse");
        chk("R2", cur_addr, 32'(exp_addr), "store address");
        chk("R2", wr_data, 32'(d), "store data");
        serve(int'($urandom % 4), noise);
        exp_addr = next_addr(exp_addr);
        exp_cnt  = next_cnt(exp_cnt);
        chk("R3", busy, 0, "idle after store done");
        chk(exp_addr == 0 ? "R4" : "R3", cur_addr, 32'(exp_addr), "pointer after store");
        chk(exp_cnt == 0 ? "R5" : "R3", byte_count, 32'(exp_cnt), "count after store");
    endtask

    task automatic do_erase(input bit with_store);
        @(negedge clk);
        wr_done = 1'b0; erase_req = 1'b1; store_req = with_store; store_data = 8'hA5;
        @(posedge clk); #1;
        chk(with_store ? "R9" : "R6", wr_start, 1, "erase first command");
        chk(with_store ? "R9" : "R6", cur_addr, 0, "erase first address");
        chk(with_store ? "R9" : "R6", wr_data, 0, "erase fill value");
        for (int i = 0; i < 128; i++) begin
            serve(int'($urandom % 3), (i % 17) == 3);
            if (i < 127) begin
                chk("R6", wr_start, 1, "next erase command");
                chk("R6", cur_addr, 32'(i + 1), "erase address order");
                chk("R6", wr_data, 0, "erase data");
                chk("R6", busy, 1, "busy during erase");
            end
        end
        exp_addr = 0;
        exp_cnt  = 0;
        chk("R7", busy, 0, "idle after erase");
        chk("R7", cur_addr, 0, "pointer after erase");
        chk("R7", byte_count, 0, "count after erase");
    endtask

    // Watchdog: a hung run counts as a failed check and still reports
    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog (all): actual %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk("R1", busy, 0, "busy in reset");
        chk("R1", wr_start, 0, "start in reset");
        chk("R1", cur_addr, 0, "pointer in reset");
        chk("R1", byte_count, 0, "count in reset");
        @(negedge clk) rst_n = 1'b1;

        // Directed stores
        do_store(8'h37, 1'b0);
        do_store(8'hFF, 1'b1);
        do_store(8'h00, 1'b0);

        // Done pulse with nothing in flight
        @(negedge clk);
        wr_done = 1'b1;
        @(posedge clk); #1;
        chk("R10", cur_addr, 32'(exp_addr), "pointer after stray done");
        chk("R10", byte_count, 32'(exp_cnt), "count after stray done");
        chk("R10", busy, 0, "idle after stray done");

        // Store and erase together: erase is taken
        do_erase(1'b1);

        // Random stores across the pointer and counter rollovers
        for (int n = 0; n < 262; n++)
            do_store(8'($urandom), ($urandom % 4) == 0);

        // Plain erase, then stores restart from zero
        do_erase(1'b0);
        do_store(8'h5A, 1'b0);
        do_store(8'hC3, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule